// File: doc/BRIEF.md
# Indirect Data Memory Access Unit

This block is the address path of an 8-bit data memory with two pointer-based indirect locations. The core gives it a direct address, read and write strobes, write data and a bank select. It resolves each access to one of five targets: a general data memory word, one of the two pointer registers, a word of a separate display memory, or nothing at all. It then drives the write enables and returns the read data.

Address 00h uses the first pointer as the effective address, and address 02h uses the second. Only the second pointer can reach the display memory, and only while the bank select is high during the access. Neither indirect location holds storage. An indirect access whose pointer names 00h or 02h in the data memory returns zero on a read and changes nothing on a write. The accumulator lives at address 05h as ordinary storage, and its contents are shown on a dedicated output.

Top module: `idm_access_unit`

## Requirements
- R1: After reset both pointers, every data memory and display memory word, `rdata_o` and `acc_o` are zero.
- R2: A direct access to an address from 04h to DMEM_DEPTH-1 reads or writes that data memory word. Read data appears on `rdata_o` in the cycle after `rd_i` was high. In any cycle that follows one without `rd_i`, `rdata_o` is zero.
- R3: The first pointer is read and written directly at 01h and the second at 03h. A pointer changes only on a write that resolves to it.
- R4: An access to 00h uses the first pointer as its effective address and always targets the data memory side, whatever the value of `disp_sel_i`.
- R5: An access to 02h uses the second pointer as its effective address. It targets the data memory side when `disp_sel_i` is 0 and the display memory word at that index when `disp_sel_i` is 1.
- R6: An indirect access on the data memory side whose pointer holds 00h or 02h reads zero, and its write changes no storage and raises no write enable.
- R7: `acc_o` always shows the data memory word at 05h. It changes only after a write to that word.
- R8: A data memory side effective address of DMEM_DEPTH or more, or a display index of DISP_DEPTH or more, reads zero and ignores writes.
- R9: `dmem_we_o` is high exactly in a write cycle that resolves to a data memory word. `disp_we_o` is high exactly in a write cycle that resolves to a display word. The two are never high together. `ea_o` shows the effective address of the current access combinationally.
- R10: When `rd_i` and `wr_i` are both high, the write is performed and the read in the next cycle returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Direct address from the core |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| disp_sel_i | input | 1 | Routes accesses made through the second pointer to the display memory |
| rdata_o | output | 8 | Read data, one cycle after the strobe |
| acc_o | output | 8 | Contents of the accumulator word at 05h |
| ea_o | output | 8 | Effective address of the current access |
| dmem_we_o | output | 1 | Write enable of the data memory |
| disp_we_o | output | 1 | Write enable of the display memory |

## Verification
The assertions check on every cycle that the write enables are mutually exclusive and always tied to a write strobe. They also check that only address 02h with the select high can write the display memory, that pointers naming an indirect location give a zero read and no enable, that an idle cycle leaves `rdata_o` at zero, and that the pointers and the accumulator hold without writes. Only the bench's scenarios can show that data written along one path is read back along another: direct against indirect, and display against data memory. They also cover the out-of-range cases, a pointer rewritten through itself, and the combined read and write access, checked against a behavioural memory model.

// File: rtl/idm_pkg.sv
package idm_pkg;
  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_DMEM = 3'd1,
    TGT_DISP = 3'd2,
    TGT_MP0  = 3'd3,
    TGT_MP1  = 3'd4
  } tgt_e;
endpackage

// File: rtl/idm_decode.sv
module idm_decode
  import idm_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                DMEM_DEPTH = 128,
  parameter int                DISP_DEPTH = 32,
  parameter logic [ADDR_W-1:0] IND0_A     = '0,
  parameter logic [ADDR_W-1:0] PTR0_A     = '0,
  parameter logic [ADDR_W-1:0] IND1_A     = '0,
  parameter logic [ADDR_W-1:0] PTR1_A     = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] mp0_i,
  input  logic [ADDR_W-1:0] mp1_i,
  input  logic              disp_sel_i,
  output tgt_e              tgt_o,
  output logic [ADDR_W-1:0] ea_o
);
  localparam logic [ADDR_W:0] DMEM_LIM = (ADDR_W+1)'(DMEM_DEPTH);
  localparam logic [ADDR_W:0] DISP_LIM = (ADDR_W+1)'(DISP_DEPTH);

  logic to_disp;

  always_comb begin
    ea_o    = addr_i;
    to_disp = 1'b0;
    if (addr_i == IND0_A) begin
      ea_o = mp0_i;
    end else if (addr_i == IND1_A) begin
      ea_o    = mp1_i;
      to_disp = disp_sel_i;
    end

    tgt_o = TGT_NONE;
    if (to_disp) begin
      if ({1'b0, ea_o} < DISP_LIM) tgt_o = TGT_DISP;
    end else if (ea_o == IND0_A || ea_o == IND1_A) begin
      tgt_o = TGT_NONE;  // pointer names an indirect slot: null access
    end else if (ea_o == PTR0_A) begin
      tgt_o = TGT_MP0;
    end else if (ea_o == PTR1_A) begin
      tgt_o = TGT_MP1;
    end else if ({1'b0, ea_o} < DMEM_LIM) begin
      tgt_o = TGT_DMEM;
    end
  end
endmodule

// File: rtl/idm_ptr_regs.sv
module idm_ptr_regs #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we0_i,
  input  logic              we1_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] mp0_o,
  output logic [ADDR_W-1:0] mp1_o
);
  logic [ADDR_W-1:0] mp0_q, mp1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mp0_q <= '0;
      mp1_q <= '0;
    end else begin
      if (we0_i) mp0_q <= wdata_i;
      if (we1_i) mp1_q <= wdata_i;
    end
  end

  assign mp0_o = mp0_q;
  assign mp1_o = mp1_q;
endmodule

// File: rtl/idm_store.sv
module idm_store #(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 32,
  parameter int IW      = $clog2(DEPTH),
  parameter int TAP_IDX = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IW-1:0]     widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IW-1:0]     ridx_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] tap_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];

  generate
    if (TAP_IDX < DEPTH) begin : g_tap
      assign tap_o = mem_q[TAP_IDX];
    end else begin : g_no_tap
      assign tap_o = '0;
    end
  endgenerate
endmodule

// File: rtl/idm_access_unit.sv
module idm_access_unit
  import idm_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 8,
  parameter int DMEM_DEPTH = 128,
  parameter int DISP_DEPTH = 32,
  parameter int ACC_ADDR   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              disp_sel_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [ADDR_W-1:0] ea_o,
  output logic              dmem_we_o,
  output logic              disp_we_o
);
  localparam logic [ADDR_W-1:0] IND0_A  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] PTR0_A  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] IND1_A  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] PTR1_A  = ADDR_W'(3);
  localparam int                DMEM_IW = $clog2(DMEM_DEPTH);
  localparam int                DISP_IW = $clog2(DISP_DEPTH);

  tgt_e              tgt_d, tgt_q;
  logic [ADDR_W-1:0] ea_d;
  logic [ADDR_W-1:0] mp0_q, mp1_q;
  logic [DMEM_IW-1:0] dmem_ridx_q;
  logic [DISP_IW-1:0] disp_ridx_q;
  logic [DATA_W-1:0] dmem_rdata, disp_rdata, disp_tap_unused;
  logic              dmem_we, disp_we, mp0_we, mp1_we;

  idm_decode #(
    .ADDR_W    (ADDR_W),
    .DMEM_DEPTH(DMEM_DEPTH),
    .DISP_DEPTH(DISP_DEPTH),
    .IND0_A    (IND0_A),
    .PTR0_A    (PTR0_A),
    .IND1_A    (IND1_A),
    .PTR1_A    (PTR1_A)
  ) u_decode (
    .addr_i    (addr_i),
    .mp0_i     (mp0_q),
    .mp1_i     (mp1_q),
    .disp_sel_i(disp_sel_i),
    .tgt_o     (tgt_d),
    .ea_o      (ea_d)
  );

  assign dmem_we = wr_i && (tgt_d == TGT_DMEM);
  assign disp_we = wr_i && (tgt_d == TGT_DISP);
  assign mp0_we  = wr_i && (tgt_d == TGT_MP0);
  assign mp1_we  = wr_i && (tgt_d == TGT_MP1);

  idm_ptr_regs #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we0_i  (mp0_we),
    .we1_i  (mp1_we),
    .wdata_i(ADDR_W'(wdata_i)),
    .mp0_o  (mp0_q),
    .mp1_o  (mp1_q)
  );

  idm_store #(
    .DATA_W (DATA_W),
    .DEPTH  (DMEM_DEPTH),
    .IW     (DMEM_IW),
    .TAP_IDX(ACC_ADDR)
  ) u_dmem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (dmem_we),
    .widx_i (ea_d[DMEM_IW-1:0]),
    .wdata_i(wdata_i),
    .ridx_i (dmem_ridx_q),
    .rdata_o(dmem_rdata),
    .tap_o  (acc_o)
  );

  idm_store #(
    .DATA_W (DATA_W),
    .DEPTH  (DISP_DEPTH),
    .IW     (DISP_IW),
    .TAP_IDX(0)
  ) u_disp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (disp_we),
    .widx_i (ea_d[DISP_IW-1:0]),
    .wdata_i(wdata_i),
    .ridx_i (disp_ridx_q),
    .rdata_o(disp_rdata),
    .tap_o  (disp_tap_unused)
  );

  // read target and index registered; data muxed combinationally afterwards
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q       <= TGT_NONE;
      dmem_ridx_q <= '0;
      disp_ridx_q <= '0;
    end else begin
      tgt_q       <= rd_i ? tgt_d : TGT_NONE;
      dmem_ridx_q <= ea_d[DMEM_IW-1:0];
      disp_ridx_q <= ea_d[DISP_IW-1:0];
    end
  end

  always_comb begin
    unique case (tgt_q)
      TGT_DMEM: rdata_o = dmem_rdata;
      TGT_DISP: rdata_o = disp_rdata;
      TGT_MP0:  rdata_o = DATA_W'(mp0_q);
      TGT_MP1:  rdata_o = DATA_W'(mp1_q);
      default:  rdata_o = '0;
    endcase
  end

  assign ea_o      = ea_d;
  assign dmem_we_o = dmem_we;
  assign disp_we_o = disp_we;
endmodule

// File: rtl/idm_access_chk.sv
module idm_access_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic              disp_sel_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] acc_o,
  input logic [ADDR_W-1:0] ea_o,
  input logic              dmem_we_o,
  input logic              disp_we_o,
  input logic [ADDR_W-1:0] mp0_q,
  input logic [ADDR_W-1:0] mp1_q
);
  localparam logic [ADDR_W-1:0] I0 = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] I1 = ADDR_W'(2);

  // R9
  we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dmem_we_o && disp_we_o));

  // R9
  we_needs_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_we_o || disp_we_o) |-> wr_i);

  // R5
  disp_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_we_o |-> (addr_i == I1) && disp_sel_i);

  // R4
  mp0_ea_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == I0) |-> (ea_o == mp0_q) && !disp_we_o);

  // R6
  null_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == I0 && (mp0_q == I0 || mp0_q == I1)) |=> (rdata_o == '0));

  // R6
  null_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == I1 && !disp_sel_i && (mp1_q == I0 || mp1_q == I1))
      |-> !dmem_we_o && !disp_we_o);

  // R2
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_o == '0));

  // R7
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dmem_we_o |=> $stable(acc_o));

  // R3
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mp0_q) && $stable(mp1_q));
endmodule

bind idm_access_unit idm_access_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .rd_i      (rd_i),
  .wr_i      (wr_i),
  .disp_sel_i(disp_sel_i),
  .rdata_o   (rdata_o),
  .acc_o     (acc_o),
  .ea_o      (ea_o),
  .dmem_we_o (dmem_we_o),
  .disp_we_o (disp_we_o),
  .mp0_q     (mp0_q),
  .mp1_q     (mp1_q)
);

// File: tb/tb_idm_access_unit.sv
module tb_idm_access_unit;
  localparam int DMEM_DEPTH = 128;
  localparam int DISP_DEPTH = 32;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0, sel = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, acc, ea;
  logic       dmem_we, disp_we;

  always #10 clk = ~clk;  // 50 MHz

  idm_access_unit #(.DMEM_DEPTH(DMEM_DEPTH), .DISP_DEPTH(DISP_DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .disp_sel_i(sel), .rdata_o(rdata), .acc_o(acc),
    .ea_o(ea), .dmem_we_o(dmem_we), .disp_we_o(disp_we)
  );

  // behavioural reference
  int   m_dmem [256];
  int   m_disp [256];
  int   m_mp0 = 0, m_mp1 = 0;
  int   exp_rd = 0;
  int   checks = 0, fails = 0;
  bit   done = 0;

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // kind: 0 none, 1 dmem, 2 disp, 3 mp0, 4 mp1
  task automatic resolve(input int a, input bit s, output int kind, output int eff);
    bit d = 0;
    eff = a;
    if (a == 0) eff = m_mp0;
    else if (a == 2) begin eff = m_mp1; d = s; end
    if (d) kind = (eff < DISP_DEPTH) ? 2 : 0;
    else if (eff == 0 || eff == 2) kind = 0;
    else if (eff == 1) kind = 3;
    else if (eff == 3) kind = 4;
    else kind = (eff < DMEM_DEPTH) ? 1 : 0;
  endtask

  task automatic access(string req, int a, bit r, bit w, int wd, bit s);
    int kind, eff;
    @(negedge clk);
    chk(req, int'(rdata), exp_rd, "rdata");
    chk("R7", int'(acc), m_dmem[5], "acc");
    addr = 8'(a); rd = r; wr = w; wdata = 8'(wd); sel = s;
    #1;
    resolve(a, s, kind, eff);
    chk("R9", int'(ea), eff, "ea");
    chk("R9", int'(dmem_we), int'(w && kind == 1), "dmem_we");
    chk("R9", int'(disp_we), int'(w && kind == 2), "disp_we");
    if (w) begin
      case (kind)
        1: m_dmem[eff] = wd;
        2: m_disp[eff] = wd;
        3: m_mp0 = wd;
        4: m_mp1 = wd;
        default: ;
      endcase
    end
    if (!r) exp_rd = 0;
    else case (kind)
      1: exp_rd = m_dmem[eff];
      2: exp_rd = m_disp[eff];
      3: exp_rd = m_mp0;
      4: exp_rd = m_mp1;
      default: exp_rd = 0;
    endcase
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin m_dmem[i] = 0; m_disp[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(rdata), 0, "rdata at reset");
    chk("R1", int'(acc), 0, "acc at reset");
    rst_ni = 1'b1;
    access("R1", 8'h01, 1, 0, 0, 0);
    access("R1", 8'h03, 1, 0, 0, 0);
    access("R1", 8'h40, 1, 0, 0, 0);
    access("R1", 8'h02, 1, 0, 0, 1);
    // R2 direct
    access("R2", 8'h10, 0, 1, 8'hA5, 0);
    access("R2", 8'h7F, 0, 1, 8'h3C, 0);
    access("R2", 8'h10, 1, 0, 0, 0);
    access("R2", 8'h7F, 1, 0, 0, 0);
    access("R2", 8'h10, 0, 0, 0, 0);
    // R7 accumulator
    access("R7", 8'h05, 0, 1, 8'h77, 0);
    access("R7", 8'h05, 1, 0, 0, 0);
    // R3 pointers
    access("R3", 8'h01, 1, 1, 8'h10, 0);
    access("R3", 8'h03, 1, 1, 8'h7F, 0);
    access("R3", 8'h01, 1, 0, 0, 1);
    // R4 indirect via first pointer, select ignored
    access("R4", 8'h00, 1, 0, 0, 1);
    access("R4", 8'h00, 0, 1, 8'h5A, 1);
    access("R4", 8'h10, 1, 0, 0, 0);
    // R5 second pointer, both banks
    access("R5", 8'h02, 1, 0, 0, 0);
    access("R5", 8'h03, 0, 1, 8'h07, 0);
    access("R5", 8'h02, 0, 1, 8'hC3, 1);
    access("R5", 8'h02, 1, 0, 0, 1);
    access("R5", 8'h07, 1, 0, 0, 0);
    access("R5", 8'h02, 1, 0, 0, 0);
    // R6 null pointers
    access("R6", 8'h01, 0, 1, 8'h00, 0);
    access("R6", 8'h00, 0, 1, 8'hEE, 0);
    access("R6", 8'h00, 1, 0, 0, 0);
    access("R6", 8'h01, 0, 1, 8'h02, 0);
    access("R6", 8'h00, 1, 1, 8'hEE, 1);
    access("R6", 8'h03, 0, 1, 8'h02, 0);
    access("R6", 8'h02, 1, 1, 8'h99, 0);
    access("R6", 8'h02, 1, 1, 8'h44, 1);
    access("R6", 8'h02, 1, 0, 0, 1);
    // pointer reaching itself
    access("R3", 8'h01, 0, 1, 8'h01, 0);
    access("R3", 8'h00, 1, 1, 8'h20, 0);
    access("R3", 8'h01, 1, 0, 0, 0);
    // R8 out of range
    access("R8", 8'h80, 1, 1, 8'h11, 0);
    access("R8", 8'hFF, 1, 0, 0, 0);
    access("R8", 8'h03, 0, 1, 8'h40, 0);
    access("R8", 8'h02, 1, 1, 8'h22, 1);
    access("R8", 8'h02, 1, 0, 0, 0);
    // R10 read with write
    access("R10", 8'h30, 1, 1, 8'h6B, 0);
    access("R10", 8'h03, 1, 1, 8'h1F, 0);
    access("R10", 8'h02, 1, 1, 8'hD2, 1);
    for (int i = 0; i < 400; i++) begin
      int a = $urandom_range(0, 11);
      if (i % 5 == 0) a = $urandom_range(0, 255);
      access("R2", a, 1'($urandom), 1'($urandom), $urandom_range(0, 255), 1'($urandom));
    end
    access("R2", 8'h00, 0, 0, 0, 0);
    access("R2", 8'h00, 0, 0, 0, 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule